// File: doc/BRIEF.md
# Root contention engine

This block resolves a tie between two nodes that both want to become root on one serial link. After a start pulse each node, in an order picked at random, draws a weighted coin and commits to a fast or a slow back-off. The first node waits out the programmable wire delay before the second commits. Once both have committed, a shared half-step timer measures the back-off. If the two nodes picked different speeds, the contention resolves after a fixed window shortened by the wire delay. If they picked the same speed, the engine either resolves early or gives up and starts a new round.

Randomness comes from an internal 16-bit maximal-length LFSR, which is loaded from a seed on every start pulse. A run is therefore repeatable for a given seed. An 8-bit probability threshold sets how likely a node is to pick fast, and the end values of that threshold give exact certainties. A saturating counter reports how many rounds were retried since the last start. The current state is visible on a port, so a host can follow the whole contention.

Top module: `rc_engine`

## Requirements
- R1: After reset the state is idle (code 10), and resolved, both speed flags and the retry count are 0.
- R2: A start pulse, accepted in any state, puts the engine in the no-choice state (code 0) on the next cycle with the retry count cleared. The no-choice state lasts exactly one cycle and is followed by a one-chosen state (codes 1 to 4).
- R3: One-chosen state codes are: 1 A fast, 2 B fast, 3 B slow, 4 A slow. Each lasts 2*delay+1 cycles while the timer climbs to the wire delay in half steps. The other node then chooses: 1 leads to 5 or 6, 2 to 5 or 7, 3 to 6 or 8, 4 to 7 or 8.
- R4: The speed flags (1 = fast) match the state. In a one-chosen state the flag of the node that has not chosen is 0. Both-chosen codes are: 5 fast/fast, 6 A fast B slow, 7 A slow B fast, 8 slow/slow.
- R5: A probability threshold of 0 makes every choice slow, and a threshold of 255 makes every choice fast.
- R6: A mixed state (6 or 7) lasts 2*max(159-delay,0)+1 cycles and then always enters done. It never restarts.
- R7: The fast/fast state either enters done after 2*max(76-delay,0)+1 cycles or returns to code 0 after 153 cycles.
- R8: The slow/slow state either enters done after 2*max(159-delay,0)+1 cycles or returns to code 0 after 319 cycles.
- R9: On entry to a both-chosen state the timer is cleared. The timer never passes its cap: 85 for fast/fast and 167 for the other both-chosen states.
- R10: Done (code 9) holds until the next start pulse. The resolved output is 1 exactly in done.
- R11: Each restart adds one to the retry count, which saturates at its maximum.
- R12: A zero seed is replaced by a non-zero one, so the LFSR never locks up and the contention still completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a new contention, reload the LFSR seed |
| seed_i | input | 16 | LFSR seed taken on start |
| delay_i | input | 8 | Wire delay in timer units |
| prob_i | input | 8 | Probability threshold for choosing fast |
| resolved_o | output | 1 | Contention resolved (done state) |
| speed_a_o | output | 1 | Node A chose fast |
| speed_b_o | output | 1 | Node B chose fast |
| retry_o | output | 8 | Saturating count of restarted rounds |
| state_o | output | 4 | Current state code |

## Verification
The mixed outcomes are the hardest to reach from the ports, because the two nodes draw from the same threshold. Only the LFSR sequence can make their choices differ. The bench therefore sets the threshold to its midpoint and walks through seeds until a run shows a fast/slow or slow/fast state, then checks that state's window length and that it ends in done. The two threshold end values force the matched states deterministically, and large wire delays drive the saturated thresholds to zero.

// File: rtl/rc_pkg.sv
package rc_pkg;

    typedef enum logic [3:0] {
        ST_NONE = 4'd0,
        ST_AF   = 4'd1,
        ST_BF   = 4'd2,
        ST_BS   = 4'd3,
        ST_AS   = 4'd4,
        ST_FF   = 4'd5,
        ST_FS   = 4'd6,
        ST_SF   = 4'd7,
        ST_SS   = 4'd8,
        ST_DONE = 4'd9,
        ST_IDLE = 4'd10
    } rc_state_e;

    function automatic logic is_single(rc_state_e s);
        return (s == ST_AF) || (s == ST_BF) || (s == ST_BS) || (s == ST_AS);
    endfunction

    function automatic logic is_both(rc_state_e s);
        return (s == ST_FF) || (s == ST_FS) || (s == ST_SF) || (s == ST_SS);
    endfunction

    function automatic logic is_mixed(rc_state_e s);
        return (s == ST_FS) || (s == ST_SF);
    endfunction

endpackage

// File: rtl/rc_lfsr.sv
module rc_lfsr #(
    parameter int          WIDTH = 16,
    parameter logic [15:0] TAPS  = 16'hB400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] seed_i,
    output logic [WIDTH-1:0] value_o
);
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
    localparam logic [WIDTH-1:0] MASK = WIDTH'(TAPS);

    logic [WIDTH-1:0] lfsr_d, lfsr_q;

    always_comb begin
        if (load_i) begin
            lfsr_d = (seed_i == '0) ? ONE : seed_i;
        end else begin
            lfsr_d = {1'b0, lfsr_q[WIDTH-1:1]} ^ (lfsr_q[0] ? MASK : '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= ONE;
        else        lfsr_q <= lfsr_d;
    end

    assign value_o = lfsr_q;

    // R12: lock-up state never reached
    assert_lfsr_nonzero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (lfsr_q != '0));
    assert_lfsr_stays_live_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (lfsr_q != '0) |=> (lfsr_q != '0));

endmodule

// File: rtl/rc_coin.sv
module rc_coin #(
    parameter int LFSR_W = 16,
    parameter int PROB_W = 8
) (
    input  logic [LFSR_W-1:0] rand_i,
    input  logic [PROB_W-1:0] prob_i,
    output logic              fast_o
);
    localparam int SHIFT = LFSR_W - PROB_W;

    logic [LFSR_W-1:0] scaled;

    generate
        if (SHIFT > 0) begin : g_scale
            assign scaled = {prob_i, {SHIFT{1'b0}}};
        end else begin : g_same
            assign scaled = LFSR_W'(prob_i);
        end
    endgenerate

    always_comb begin
        if (prob_i == '1)      fast_o = 1'b1;
        else if (prob_i == '0) fast_o = 1'b0;
        else                   fast_o = (rand_i < scaled);
    end

endmodule

// File: rtl/rc_thresh.sv
module rc_thresh #(
    parameter int DLY_W = 8,
    parameter int CNT_W = 8,
    parameter int BASE  = 159
) (
    input  logic [DLY_W-1:0] delay_i,
    output logic [CNT_W-1:0] thr_o
);
    always_comb begin
        if (int'(delay_i) >= BASE) thr_o = '0;
        else                       thr_o = CNT_W'(BASE - int'(delay_i));
    end

endmodule

// File: rtl/rc_engine.sv
module rc_engine
    import rc_pkg::*;
#(
    parameter int          LFSR_W  = 16,
    parameter logic [15:0] TAPS    = 16'hB400,
    parameter int          PROB_W  = 8,
    parameter int          DLY_W   = 8,
    parameter int          RETRY_W = 8,
    parameter int          FF_MIN  = 76,
    parameter int          FF_CAP  = 85,
    parameter int          SS_MIN  = 159,
    parameter int          SS_CAP  = 167
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [LFSR_W-1:0]  seed_i,
    input  logic [DLY_W-1:0]   delay_i,
    input  logic [PROB_W-1:0]  prob_i,
    output logic               resolved_o,
    output logic               speed_a_o,
    output logic               speed_b_o,
    output logic [RETRY_W-1:0] retry_o,
    output logic [3:0]         state_o
);
    localparam int CAP_MAX = (SS_CAP > FF_CAP) ? SS_CAP : FF_CAP;
    localparam int CNT_W   = $clog2(CAP_MAX + 1) > DLY_W ? $clog2(CAP_MAX + 1) : DLY_W;
    localparam logic [CNT_W-1:0] FF_MIN_C = CNT_W'(FF_MIN);
    localparam logic [CNT_W-1:0] SS_MIN_C = CNT_W'(SS_MIN);
    localparam logic [CNT_W-1:0] FF_CAP_C = CNT_W'(FF_CAP);
    localparam logic [CNT_W-1:0] SS_CAP_C = CNT_W'(SS_CAP);

    typedef struct packed {
        rc_state_e          state;
        logic [CNT_W-1:0]   cnt;
        logic               half;
        logic               hold;
        logic               spd_a;
        logic               spd_b;
        logic [RETRY_W-1:0] retry;
    } regs_t;

    regs_t r_d, r_q;

    logic [LFSR_W-1:0] rnd;
    logic              coin_fast;
    logic [CNT_W-1:0]  thr_fast;
    logic [CNT_W-1:0]  thr_slow;
    logic [CNT_W-1:0]  delay_c;

    rc_lfsr #(.WIDTH(LFSR_W), .TAPS(TAPS)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (start_i),
        .seed_i  (seed_i),
        .value_o (rnd)
    );

    rc_coin #(.LFSR_W(LFSR_W), .PROB_W(PROB_W)) u_coin (
        .rand_i (rnd),
        .prob_i (prob_i),
        .fast_o (coin_fast)
    );

    rc_thresh #(.DLY_W(DLY_W), .CNT_W(CNT_W), .BASE(FF_MIN)) u_thr_fast (
        .delay_i (delay_i),
        .thr_o   (thr_fast)
    );

    rc_thresh #(.DLY_W(DLY_W), .CNT_W(CNT_W), .BASE(SS_MIN)) u_thr_slow (
        .delay_i (delay_i),
        .thr_o   (thr_slow)
    );

    assign delay_c = CNT_W'(delay_i);

    // half-step advance of the shared timer
    logic [CNT_W-1:0] tick_cnt;
    logic             tick_half;
    always_comb begin
        if (r_q.half) begin
            tick_cnt  = r_q.cnt + 1'b1;
            tick_half = 1'b0;
        end else begin
            tick_cnt  = r_q.cnt;
            tick_half = 1'b1;
        end
    end

    // per-state window limits
    logic [CNT_W-1:0] cap_now;
    logic [CNT_W-1:0] res_thr;
    logic [CNT_W-1:0] rst_thr;
    always_comb begin
        cap_now = (r_q.state == ST_FF) ? FF_CAP_C : SS_CAP_C;
        res_thr = (r_q.state == ST_FF) ? thr_fast : thr_slow;
        rst_thr = (r_q.state == ST_FF) ? FF_MIN_C : SS_MIN_C;
    end

    always_comb begin
        r_d = r_q;
        if (start_i) begin
            r_d.state = ST_NONE;
            r_d.cnt   = '0;
            r_d.half  = 1'b0;
            r_d.hold  = 1'b0;
            r_d.spd_a = 1'b0;
            r_d.spd_b = 1'b0;
            r_d.retry = '0;
        end else begin
            unique case (r_q.state)
                ST_NONE: begin
                    r_d.cnt   = '0;
                    r_d.half  = 1'b0;
                    r_d.hold  = 1'b0;
                    r_d.spd_a = 1'b0;
                    r_d.spd_b = 1'b0;
                    if (!rnd[LFSR_W-1]) begin
                        r_d.spd_a = coin_fast;
                        r_d.state = coin_fast ? ST_AF : ST_AS;
                    end else begin
                        r_d.spd_b = coin_fast;
                        r_d.state = coin_fast ? ST_BF : ST_BS;
                    end
                end
                ST_AF, ST_AS, ST_BF, ST_BS: begin
                    if (r_q.cnt < delay_c) begin
                        r_d.cnt  = tick_cnt;
                        r_d.half = tick_half;
                    end else begin
                        r_d.cnt  = '0;
                        r_d.half = 1'b0;
                        r_d.hold = 1'b0;
                        unique case (r_q.state)
                            ST_AF: begin
                                r_d.spd_b = coin_fast;
                                r_d.state = coin_fast ? ST_FF : ST_FS;
                            end
                            ST_AS: begin
                                r_d.spd_b = coin_fast;
                                r_d.state = coin_fast ? ST_SF : ST_SS;
                            end
                            ST_BF: begin
                                r_d.spd_a = coin_fast;
                                r_d.state = coin_fast ? ST_FF : ST_SF;
                            end
                            default: begin
                                r_d.spd_a = coin_fast;
                                r_d.state = coin_fast ? ST_FS : ST_SS;
                            end
                        endcase
                    end
                end
                ST_FS, ST_SF: begin
                    if (r_q.cnt >= res_thr) begin
                        r_d.state = ST_DONE;
                        r_d.cnt   = '0;
                        r_d.half  = 1'b0;
                    end else if (r_q.cnt < cap_now) begin
                        r_d.cnt  = tick_cnt;
                        r_d.half = tick_half;
                    end
                end
                ST_FF, ST_SS: begin
                    if (!r_q.hold && (r_q.cnt >= res_thr) && rnd[0]) begin
                        r_d.state = ST_DONE;
                        r_d.cnt   = '0;
                        r_d.half  = 1'b0;
                    end else if (r_q.cnt >= rst_thr) begin
                        r_d.state = ST_NONE;
                        r_d.cnt   = '0;
                        r_d.half  = 1'b0;
                        r_d.hold  = 1'b0;
                        if (r_q.retry != '1) r_d.retry = r_q.retry + 1'b1;
                    end else begin
                        if (r_q.cnt >= res_thr) r_d.hold = 1'b1;
                        if (r_q.cnt < cap_now) begin
                            r_d.cnt  = tick_cnt;
                            r_d.half = tick_half;
                        end
                    end
                end
                default: begin
                    // idle and done hold
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.cnt   <= '0;
            r_q.half  <= 1'b0;
            r_q.hold  <= 1'b0;
            r_q.spd_a <= 1'b0;
            r_q.spd_b <= 1'b0;
            r_q.retry <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign resolved_o = (r_q.state == ST_DONE);
    assign speed_a_o  = r_q.spd_a;
    assign speed_b_o  = r_q.spd_b;
    assign retry_o    = r_q.retry;
    assign state_o    = 4'(r_q.state);

    // R2: start always lands in the no-choice state with retries cleared
    assert_start_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (state_o == 4'd0) && (retry_o == '0));

    // R5: threshold end values force the coin
    assert_coin_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (prob_i == '0) |-> !coin_fast);
    assert_coin_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (prob_i == '1) |-> coin_fast);

    // R6: mixed states never fall back to a new round
    assert_mixed_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mixed(r_q.state) && !start_i) |=> (is_mixed(r_q.state) || r_q.state == ST_DONE));

    // R9: timer cleared when both nodes have chosen, and held under its cap
    assert_timer_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_single(r_q.state) && !start_i) |=>
            (!is_both(r_q.state) || (r_q.cnt == '0 && !r_q.half)));
    assert_timer_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        is_both(r_q.state) |-> (r_q.cnt <= ((r_q.state == ST_FF) ? FF_CAP_C : SS_CAP_C)));

    // R10: done is absorbing until a new start
    assert_done_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (resolved_o && !start_i) |=> resolved_o);

    // R11: retry count saturates and only moves up by one
    assert_retry_sat_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((retry_o == '1) && !start_i) |=> (retry_o == '1));
    assert_retry_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !(state_o == 4'd5 || state_o == 4'd8)) |=> $stable(retry_o));

endmodule

// File: tb/rc_engine_tb.sv
module rc_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] seed_i = 16'h1;
    logic [7:0]  delay_i = 8'd0;
    logic [7:0]  prob_i = 8'd128;
    logic        resolved_o;
    logic        speed_a_o;
    logic        speed_b_o;
    logic [7:0]  retry_o;
    logic [3:0]  state_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit saw_mixed = 0;
    bit saw_restart = 0;
    bit last_done = 0;

    always #2 clk = ~clk;

    rc_engine dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .seed_i     (seed_i),
        .delay_i    (delay_i),
        .prob_i     (prob_i),
        .resolved_o (resolved_o),
        .speed_a_o  (speed_a_o),
        .speed_b_o  (speed_b_o),
        .retry_o    (retry_o),
        .state_o    (state_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=190000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int satsub(int a, int b);
        return (a > b) ? a - b : 0;
    endfunction

    task automatic pulse_start();
        @(posedge clk); #1 start_i = 1'b1;
        @(posedge clk); #1 start_i = 1'b0;
    endtask

    function automatic bit spd_ok(int st, bit a, bit b);
        case (st)
            1: return a && !b;
            2: return !a && b;
            3, 4, 8: return !a && !b;
            5: return a && b;
            6: return a && !b;
            7: return !a && b;
            default: return 1'b1;
        endcase
    endfunction

    task automatic eval_seg(input int cur, input int len, input int nxt, input int d,
                            inout int exp_retry);
        int fthr = satsub(76, d);
        int sthr = satsub(159, d);
        case (cur)
            0: chk(len == 1 && nxt >= 1 && nxt <= 4, "R2 no-choice length", len, 1);
            1, 2, 3, 4: begin
                bit nok;
                chk(len == 2 * d + 1, "R3 one-chosen length", len, 2 * d + 1);
                nok = (cur == 1 && (nxt == 5 || nxt == 6)) || (cur == 2 && (nxt == 5 || nxt == 7)) ||
                      (cur == 3 && (nxt == 6 || nxt == 8)) || (cur == 4 && (nxt == 7 || nxt == 8));
                chk(nok, "R3 second choice", nxt, cur);
            end
            6, 7: begin
                saw_mixed = 1;
                chk(nxt == 9 && len == 2 * sthr + 1, "R6 mixed window", len, 2 * sthr + 1);
            end
            5: begin
                chk((nxt == 9 && len == 2 * fthr + 1) || (nxt == 0 && len == 153),
                    "R7 fast/fast window", len, (nxt == 9) ? 2 * fthr + 1 : 153);
                if (nxt == 0) begin
                    saw_restart = 1;
                    if (exp_retry < 255) exp_retry++;
                    chk(int'(retry_o) == exp_retry, "R11 retry count", int'(retry_o), exp_retry);
                end
            end
            8: begin
                chk((nxt == 9 && len == 2 * sthr + 1) || (nxt == 0 && len == 319),
                    "R8 slow/slow window", len, (nxt == 9) ? 2 * sthr + 1 : 319);
                if (nxt == 0) begin
                    saw_restart = 1;
                    if (exp_retry < 255) exp_retry++;
                    chk(int'(retry_o) == exp_retry, "R11 retry count", int'(retry_o), exp_retry);
                end
            end
            default: chk(1'b0, "R2 unexpected state", cur, 0);
        endcase
    endtask

    // follows one contention from the no-choice state until done
    task automatic measure(input int d, input int p);
        int cur, len, st, exp_retry, bad_spd, bad_res, bad_prob;
        exp_retry = 0; bad_spd = 0; bad_res = 0; bad_prob = 0;
        last_done = 0;
        @(negedge clk);
        cur = int'(state_o); len = 1;
        chk(cur == 0 && retry_o == 0, "R2 entry after start", cur, 0);
        for (int i = 0; i < 8000; i++) begin
            @(negedge clk);
            st = int'(state_o);
            if (!spd_ok(st, speed_a_o, speed_b_o)) bad_spd++;
            if (resolved_o != (st == 9)) bad_res++;
            if (p == 255 && (st == 3 || st == 4 || st == 6 || st == 7 || st == 8)) bad_prob++;
            if (p == 0 && (st == 1 || st == 2 || st == 5 || st == 6 || st == 7)) bad_prob++;
            if (st == cur) begin
                len++;
            end else begin
                eval_seg(cur, len, st, d, exp_retry);
                cur = st; len = 1;
                if (st == 9) begin
                    last_done = 1;
                    break;
                end
            end
        end
        chk(last_done, "R10 reached done", int'(state_o), 9);
        chk(bad_spd == 0, "R4 speed flags vs state", bad_spd, 0);
        chk(bad_res == 0, "R10 resolved only in done", bad_res, 0);
        if (p == 0 || p == 255) chk(bad_prob == 0, "R5 forced coin", bad_prob, 0);
    endtask

    task automatic run_one(input logic [15:0] s, input logic [7:0] p, input logic [7:0] d);
        seed_i = s; prob_i = p; delay_i = d;
        pulse_start();
        measure(int'(d), int'(p));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(state_o == 4'd10, "R1 reset state", int'(state_o), 10);
        chk(!resolved_o && !speed_a_o && !speed_b_o, "R1 reset flags",
            int'({resolved_o, speed_a_o, speed_b_o}), 0);
        chk(retry_o == 8'd0, "R1 reset retry", int'(retry_o), 0);
    endtask

    task automatic t_fast_only();
        saw_restart = 0;
        for (int i = 1; i <= 12; i++) run_one(16'(i * 977), 8'd255, 8'(i % 4 * 9));
        run_one(16'h3A5C, 8'd255, 8'd90);
        chk(saw_restart, "R11 fast/fast restart seen", int'(saw_restart), 1);
    endtask

    task automatic t_slow_only();
        run_one(16'h1234, 8'd0, 8'd5);
        run_one(16'h0F0F, 8'd0, 8'd200);
        run_one(16'hBEEF, 8'd0, 8'd0);
    endtask

    task automatic t_mixed_search();
        saw_mixed = 0;
        for (int s = 1; s <= 60 && !saw_mixed; s++) run_one(16'(s * 4099 + 7), 8'd128, 8'd7);
        chk(saw_mixed, "R6 mixed state reached", int'(saw_mixed), 1);
        saw_mixed = 0;
        for (int s = 1; s <= 60 && !saw_mixed; s++) run_one(16'(s * 2311 + 3), 8'd128, 8'd170);
        chk(saw_mixed, "R6 mixed with saturated threshold", int'(saw_mixed), 1);
    endtask

    task automatic t_done_hold();
        int bad = 0;
        run_one(16'h00AA, 8'd255, 8'd3);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (state_o != 4'd9 || !resolved_o) bad++;
        end
        chk(bad == 0, "R10 done holds", bad, 0);
    endtask

    task automatic t_restart_midway();
        seed_i = 16'h5151; prob_i = 8'd255; delay_i = 8'd20;
        pulse_start();
        repeat (8) @(negedge clk);
        chk(state_o == 4'd1 || state_o == 4'd2, "R2 mid-run state before restart", int'(state_o), 1);
        pulse_start();
        measure(20, 255);
    endtask

    task automatic t_seed_zero();
        run_one(16'h0000, 8'd255, 8'd2);
        chk(last_done, "R12 zero seed completes", int'(last_done), 1);
        run_one(16'h0000, 8'd0, 8'd2);
        chk(last_done, "R12 zero seed slow completes", int'(last_done), 1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_fast_only();
        t_slow_only();
        t_mixed_search();
        t_done_hold();
        t_restart_midway();
        t_seed_zero();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule